// File: doc/BRIEF.md
# Run-time configurable serial transceiver

This block sends and receives asynchronous serial frames on two separate lines. A frame is one low start bit, then a programmable number of data bits sent least significant bit first, then one or more high stop bits. The bit period, the data bit count and the stop bit count come in on input pins, so the logic that drives them can change them while the chip runs. An all-zero setting selects the built-in default (5208 clocks per bit, 8 data bits, 1 stop bit), so with the configuration pins tied low the block works straight out of reset at 9600 bps from a 50 MHz clock.

Bytes enter and leave through a valid/acknowledge pair on each side. The transmit side acknowledges a byte as soon as its 16-entry buffer has room. The receive side presents the oldest byte from its own 16-entry buffer until the consumer acknowledges it. A loopback input feeds the transmitter's serial output into the receiver and holds the outgoing line idle, so the serial path can be tested without anything outside the chip.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, tx_line is high, rx_valid is low and tx_ack is low while tx_valid is low.
- R2: A transmitted frame is a low start bit, then the data bits least significant first, then the stop bits, which are high. Each bit lasts exactly the effective divisor in clock cycles.
- R3: The effective settings are chosen as follows. cfg_div of 0 selects 5208. cfg_dbits of 0 selects 8, and values from 9 to 15 act as 8. cfg_sbits of 0 selects 1.
- R4: With a data bit count n below 8, only n bits are sent, from bit 0 upwards. A received byte has its bits above n-1 at zero.
- R5: The transmitter holds the line high for exactly the stop bit count times the divisor before the start bit of a buffered next byte.
- R6: tx_ack is high in the same cycle as tx_valid whenever the transmit buffer holds fewer than 16 bytes, and the byte is taken on that clock edge. tx_ack is low when the buffer is full. With the serialiser busy, 17 bytes can be accepted.
- R7: rx_valid is high while the receive buffer is not empty, and rx_byte shows the oldest byte. A clock edge with rx_ack high removes that byte. Bytes come out in arrival order.
- R8: A falling edge on the idle line starts a frame. The start bit is checked half a bit period later, and the frame is abandoned if the line is high again. Data bits are sampled at their centres.
- R9: A byte that completes while 16 bytes are already buffered is dropped, and the buffered bytes are left unchanged.
- R10: With loopback high, the receiver takes the transmitter's serial stream, tx_line stays high, and rx_line is ignored.
- R11: A frame whose first stop bit samples low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 16 | Clock cycles per serial bit (0 selects default) |
| cfg_dbits | input | 4 | Data bits per frame (0 selects default) |
| cfg_sbits | input | 2 | Stop bits per frame (0 selects default) |
| loopback | input | 1 | Routes the transmit stream into the receiver |
| rx_line | input | 1 | Serial input, idle high |
| tx_line | output | 1 | Serial output, idle high |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_byte | output | 8 | Oldest received byte |
| rx_ack | input | 1 | Consumer takes rx_byte |
| tx_valid | input | 1 | Producer offers tx_byte |
| tx_byte | input | 8 | Byte to send |
| tx_ack | output | 1 | Byte taken into the transmit buffer |

## Verification
The properties assume an effective divisor of at least 4, so that the half-bit wait is never zero. They also assume that loopback changes only while both serial engines are idle and the external line is high, and that rx_ack is raised only while rx_valid is high. The stimulus sets every configuration and loopback change between frames, after the line has settled high. Its consumer acknowledges a byte only when it has seen rx_valid. Every custom divisor in the stimulus is 16.

// File: rtl/uart_xcvr.sv
`timescale 1ns/1ps
module uart_xcvr #(
  parameter int DIV_W     = 16,
  parameter int DBITS_W   = 4,
  parameter int SBITS_W   = 2,
  parameter int DEPTH     = 16,
  parameter int DEF_DIV   = 5208,
  parameter int DEF_DBITS = 8,
  parameter int DEF_SBITS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [DBITS_W-1:0] cfg_dbits,
  input  logic [SBITS_W-1:0] cfg_sbits,
  input  logic               loopback,
  input  logic               rx_line,
  output logic               tx_line,
  output logic               rx_valid,
  output logic [7:0]         rx_byte,
  input  logic               rx_ack,
  input  logic               tx_valid,
  input  logic [7:0]         tx_byte,
  output logic               tx_ack
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [DBITS_W-1:0] MAXB = DBITS_W'(8);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  // effective settings (R3)
  logic [DIV_W-1:0]   div_e;
  logic [DBITS_W-1:0] nb_e;
  logic [SBITS_W-1:0] ns_e;
  assign div_e = (cfg_div == '0) ? DIV_W'(DEF_DIV) : cfg_div;
  assign nb_e  = (cfg_dbits == '0) ? DBITS_W'(DEF_DBITS) : (cfg_dbits > MAXB) ? MAXB : cfg_dbits;
  assign ns_e  = (cfg_sbits == '0) ? SBITS_W'(DEF_SBITS) : cfg_sbits;

  // transmit buffer
  logic [7:0] tmem [DEPTH];
  logic [AW:0] twp, trp, tcount;
  logic t_load;
  assign tcount = twp - trp;
  assign tx_ack = tx_valid && (tcount != FULL);

  always_ff @(posedge clk)
    if (tx_ack) tmem[twp[AW-1:0]] <= tx_byte;

  // transmit engine
  st_t t_st;
  logic [DIV_W-1:0]   t_cnt, t_div;
  logic [DBITS_W-1:0] t_idx, t_nb;
  logic [SBITS_W-1:0] t_sidx, t_ns;
  logic [7:0] t_sh;
  logic t_q, t_tick;
  assign t_tick = (t_cnt == '0);
  assign t_load = (tcount != '0) &&
                  (t_st == S_IDLE || (t_st == S_STOP && t_tick && t_sidx == t_ns - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0;
      t_st <= S_IDLE; t_q <= 1'b1; t_cnt <= '0; t_div <= '0;
      t_idx <= '0; t_nb <= '0; t_sidx <= '0; t_ns <= '0; t_sh <= '0;
    end else begin
      if (tx_ack) twp <= twp + 1'b1;
      if (t_st != S_IDLE && !t_tick) t_cnt <= t_cnt - 1'b1;
      if (t_load) begin
        trp <= trp + 1'b1;
        t_st <= S_START; t_q <= 1'b0;
        t_sh <= tmem[trp[AW-1:0]];
        t_cnt <= div_e - 1'b1; t_div <= div_e; t_nb <= nb_e; t_ns <= ns_e;
      end else if (t_tick) begin
        case (t_st)
          S_START: begin
            t_st <= S_DATA; t_q <= t_sh[0]; t_sh <= t_sh >> 1;
            t_idx <= DBITS_W'(1); t_cnt <= t_div - 1'b1;
          end
          S_DATA: begin
            t_cnt <= t_div - 1'b1;
            if (t_idx == t_nb) begin
              t_st <= S_STOP; t_q <= 1'b1; t_sidx <= '0;
            end else begin
              t_q <= t_sh[0]; t_sh <= t_sh >> 1; t_idx <= t_idx + 1'b1;
            end
          end
          S_STOP: begin
            if (t_sidx == t_ns - 1'b1) t_st <= S_IDLE;
            else begin
              t_sidx <= t_sidx + 1'b1; t_cnt <= t_div - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_line = loopback | t_q;

  // receive front end
  logic r_s1, r_s2, r_s3, r_fall;
  assign r_fall = r_s3 & ~r_s2;

  st_t r_st;
  logic [DIV_W-1:0]   r_cnt, r_div;
  logic [DBITS_W-1:0] r_idx, r_nb;
  logic [7:0] r_sh;
  logic r_tick, r_push;
  assign r_tick = (r_cnt == '0);

  // receive buffer
  logic [7:0] rmem [DEPTH];
  logic [AW:0] rwp, rrp, rcount;
  assign rcount   = rwp - rrp;
  assign rx_valid = (rcount != '0);
  assign rx_byte  = rmem[rrp[AW-1:0]];
  assign r_push   = (r_st == S_STOP) && r_tick && r_s2 && (rcount != FULL);

  always_ff @(posedge clk)
    if (r_push) rmem[rwp[AW-1:0]] <= r_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1 <= 1'b1; r_s2 <= 1'b1; r_s3 <= 1'b1;
      r_st <= S_IDLE; r_cnt <= '0; r_div <= '0; r_idx <= '0; r_nb <= '0; r_sh <= '0;
      rwp <= '0; rrp <= '0;
    end else begin
      r_s1 <= loopback ? t_q : rx_line;
      r_s2 <= r_s1;
      r_s3 <= r_s2;
      if (r_push) rwp <= rwp + 1'b1;
      if (rx_ack && rx_valid) rrp <= rrp + 1'b1;
      if (r_st != S_IDLE && !r_tick) r_cnt <= r_cnt - 1'b1;
      case (r_st)
        S_IDLE:
          if (r_fall) begin
            r_st <= S_START; r_cnt <= (div_e >> 1) - 1'b1;
            r_div <= div_e; r_nb <= nb_e; r_sh <= '0;
          end
        S_START:
          if (r_tick) begin
            if (r_s2) r_st <= S_IDLE;
            else begin
              r_st <= S_DATA; r_cnt <= r_div - 1'b1; r_idx <= '0;
            end
          end
        S_DATA:
          if (r_tick) begin
            r_sh[r_idx[2:0]] <= r_s2;
            r_cnt <= r_div - 1'b1;
            r_idx <= r_idx + 1'b1;
            if (r_idx == r_nb - 1'b1) r_st <= S_STOP;
          end
        default:
          if (r_tick) r_st <= S_IDLE;
      endcase
    end
  end

  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_st != S_IDLE && !t_tick) |=> $stable(t_q));

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_st == S_STOP) |-> t_q);

  assert_ack_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> (tcount != '0));

  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_byte)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rcount == FULL && !rx_ack) |=> (rcount == FULL));
endmodule

// File: tb/uart_xcvr_tb.sv
`timescale 1ns/1ps
module uart_xcvr_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [15:0] cfg_div = '0;
  logic [3:0]  cfg_dbits = '0;
  logic [1:0]  cfg_sbits = '0;
  logic loopback = 1'b0;
  logic rx_line = 1'b1;
  logic tx_line, rx_valid, tx_ack;
  logic [7:0] rx_byte;
  logic rx_ack = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_byte = '0;

  uart_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dbits(cfg_dbits),
    .cfg_sbits(cfg_sbits), .loopback(loopback), .rx_line(rx_line),
    .tx_line(tx_line), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ack(rx_ack),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ack(tx_ack)
  );

  int total = 0;
  int bad = 0;
  int bdiv = 16;
  bit mon_en = 1'b0;
  logic [7:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops the scoreboard for every byte the design presents
  initial begin
    forever begin
      @(negedge clk);
      rx_ack = 1'b0;
      if (mon_en && rx_valid) begin
        if (expq.size() == 0) chk(1'b0, "R7 unexpected byte", int'(rx_byte), -1);
        else begin
          automatic logic [7:0] e = expq.pop_front();
          chk(rx_byte == e, "R7 byte order/value", int'(rx_byte), int'(e));
        end
        rx_ack = 1'b1;
      end
    end
  end

  // driver: offer one byte until accepted, optionally queue the expected echo
  task automatic send_tx(input logic [7:0] b, input logic [7:0] e, input bit enq);
    @(negedge clk);
    tx_valid = 1'b1; tx_byte = b; #1;
    while (!tx_ack) begin @(negedge clk); #1; end
    if (enq) expq.push_back(e);
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic ser(input logic [7:0] b, input int nb, input logic stopv);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (bdiv) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = b[i];
      repeat (bdiv) @(negedge clk);
    end
    rx_line = stopv;
    repeat (bdiv) @(negedge clk);
    rx_line = 1'b1;
    repeat (bdiv) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (tx_line != lvl) @(negedge clk);
    while (tx_line == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic setcfg(input logic [15:0] d, input logic [3:0] nb, input logic [1:0] ns);
    @(negedge clk);
    cfg_div = d; cfg_dbits = nb; cfg_sbits = ns;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int n;
    int acks;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_line == 1'b1, "R1 tx_line idle", int'(tx_line), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid low", int'(rx_valid), 0);
    chk(tx_ack == 1'b0, "R1 tx_ack low", int'(tx_ack), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 timing and bit order on the external line
    setcfg(16'd16, 4'd8, 2'd1);
    send_tx(8'h01, 8'h00, 1'b0);
    run_len(1'b0, n);
    chk(n == 16, "R2 start bit length", n, 16);
    repeat (200) @(negedge clk);
    send_tx(8'h5A, 8'h00, 1'b0);
    while (tx_line) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(tx_line == 1'b0, "R2 start bit level", int'(tx_line), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      chk(tx_line == ((8'h5A >> i) & 1), "R2 data bit lsb first", int'(tx_line), int'((8'h5A >> i) & 1));
    end
    repeat (16) @(negedge clk);
    chk(tx_line == 1'b1, "R2 stop bit level", int'(tx_line), 1);
    repeat (40) @(negedge clk);

    // R5 two stop bits between back-to-back frames
    setcfg(16'd16, 4'd8, 2'd2);
    send_tx(8'h00, 8'h00, 1'b0);
    send_tx(8'h00, 8'h00, 1'b0);
    run_len(1'b1, n);
    chk(n == 32, "R5 stop gap two bits", n, 32);
    run_len(1'b0, n);
    chk(n == 144, "R5 next frame low run", n, 144);
    repeat (80) @(negedge clk);

    // R10 loopback, R7 ordering
    setcfg(16'd16, 4'd8, 2'd1);
    mon_en = 1'b1;
    @(negedge clk);
    rx_line = 1'b0;
    loopback = 1'b1;
    send_tx(8'hA5, 8'hA5, 1'b1);
    send_tx(8'h3C, 8'h3C, 1'b1);
    send_tx(8'hFF, 8'hFF, 1'b1);
    send_tx(8'h00, 8'h00, 1'b1);
    repeat (60) @(negedge clk);
    chk(tx_line == 1'b1, "R10 tx_line held high in loopback", int'(tx_line), 1);
    repeat (700) @(negedge clk);
    chk(expq.size() == 0, "R10 loopback bytes delivered", expq.size(), 0);

    // R4 short data count, R3 clamp above 8
    setcfg(16'd16, 4'd5, 2'd1);
    send_tx(8'hEA, 8'h0A, 1'b1);
    repeat (200) @(negedge clk);
    setcfg(16'd16, 4'd12, 2'd1);
    send_tx(8'hC3, 8'hC3, 1'b1);
    repeat (250) @(negedge clk);
    chk(expq.size() == 0, "R3 R4 loopback widths", expq.size(), 0);
    rx_line = 1'b1;
    repeat (5) @(negedge clk);
    loopback = 1'b0;
    repeat (5) @(negedge clk);

    // R4 external receive with 5 data bits
    setcfg(16'd16, 4'd5, 2'd1);
    expq.push_back(8'h1F);
    ser(8'hFF, 5, 1'b1);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R4 upper bits zero on receive", expq.size(), 0);

    // R8 glitch rejected, then a good frame
    setcfg(16'd16, 4'd8, 2'd1);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (100) @(negedge clk);
    chk(rx_valid == 1'b0, "R8 short pulse rejected", int'(rx_valid), 0);
    expq.push_back(8'h77);
    ser(8'h77, 8, 1'b1);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R8 centre sampling", expq.size(), 0);

    // R11 framing error
    ser(8'h55, 8, 1'b0);
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0, "R11 bad stop discarded", int'(rx_valid), 0);

    // R9 overflow
    mon_en = 1'b0;
    for (int i = 0; i < 17; i++) ser(8'(8'h10 + i), 8, 1'b1);
    repeat (20) @(negedge clk);
    chk(rx_valid == 1'b1, "R9 buffer holds bytes", int'(rx_valid), 1);
    for (int i = 0; i < 16; i++) expq.push_back(8'(8'h10 + i));
    mon_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(expq.size() == 0, "R9 first sixteen kept", expq.size(), 0);
    chk(rx_valid == 1'b0, "R9 seventeenth dropped", int'(rx_valid), 0);

    // R6 transmit buffer fill in loopback
    loopback = 1'b1;
    acks = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      tx_valid = 1'b1; tx_byte = 8'(8'h40 + i); #1;
      if (tx_ack) begin acks++; expq.push_back(8'(8'h40 + i)); end
    end
    @(negedge clk);
    tx_valid = 1'b0;
    chk(acks == 17, "R6 accepted count", acks, 17);
    repeat (3000) @(negedge clk);
    chk(expq.size() == 0, "R6 all accepted bytes sent", expq.size(), 0);

    // R3 defaults with zero configuration
    loopback = 1'b0;
    setcfg(16'd0, 4'd0, 2'd0);
    send_tx(8'h81, 8'h00, 1'b0);
    run_len(1'b0, n);
    chk(n == 5208, "R3 default divisor", n, 5208);
    run_len(1'b0, n);
    chk(n == 31248, "R3 default data count", n, 31248);
    repeat (3 * 5208) @(negedge clk);
    chk(tx_line == 1'b1, "R3 default frame ends high", int'(tx_line), 1);

    finish_up();
  end
endmodule